// File: doc/BRIEF.md
# GPIO Interrupt Detector with Sticky Status

This block watches a bank of already-synchronized pin levels and raises one interrupt request when any enabled pin has seen its chosen event. Every pin has two configuration inputs, a level-mode select and an invert bit. Together they choose one of four event kinds: rising edge, falling edge, low level or high level. A detected event sets a sticky per-pin status bit. Software clears that bit by writing a one to it.

Status and enable bits are packed into 32-bit words on a small register bus with combinational reads and single-cycle writes. Word k of each bank holds pins 32k through 32k+31, with pin 32k+j in bit j. The interrupt output is high whenever a status bit and its enable bit are both set. The pin configuration storage and the input synchronizers sit outside the block and feed it through ports.

Top module: `gpio_irq_detect`

## Requirements
- R1: With level-select 0 and invert 0, a pin sets its status bit at the clock edge where its sampled level is 1 and the level sampled at the previous edge was 0.
- R2: With level-select 0 and invert 1, a pin sets its status bit at the clock edge where its sampled level is 0 and the previous sample was 1. A 0-to-1 transition does not set it.
- R3: With level-select 1 and invert 0, a pin sets its status bit at every edge where its level is 0.
- R4: With level-select 1 and invert 1, a pin sets its status bit at every edge where its level is 1. A level source that is still active sets the bit again after it has been cleared.
- R5: A bus write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: Status bits set regardless of their enable bit and stay set until cleared. The enable bits only gate the interrupt output.
- R7: When an event and a write-one-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some status bit and its matching enable bit are both 1.
- R9: Status word k is at byte address 0x80+4k and enable word k is at 0x90+4k, for k = 0, 1, 2. A write to an enable word replaces it. Other addresses read as 0.
- R10: Reset sets all status bits, enable bits and previous-sample registers to 0, and `irq` is then 0. A pin held at 1 through reset in rising-edge mode therefore sets its status bit at the first edge after reset.
- R11: Bits of the top word at or above pin count 95 read as 0 in both banks and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NPINS | Synchronized pin levels |
| trig_level | input | NPINS | Per-pin level-mode select (0 edge, 1 level) |
| trig_invert | input | NPINS | Per-pin invert (selects falling edge or high level) |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| irq | output | 1 | OR of enabled status bits |

## Verification
The bench builds the block with its default parameters: 95 pins in three 32-bit words, so the top word has one unused bit. With these values the pin-count padding in the top word, pins in the middle of a word, and every word address of both banks can all be exercised, along with all four event kinds. Random pin traffic, random mode changes and random bus writes then set-and-clear collisions and level re-sets occur in the same cycle many times.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS     = 95,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int STAT_BASE = 'h80,
  parameter int EN_BASE   = 'h90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_level,
  input  logic [NPINS-1:0] trig_level,
  input  logic [NPINS-1:0] trig_invert,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  localparam int NWORDS = (NPINS + DW - 1) / DW;
  localparam int PW = NWORDS * DW;
  localparam logic [PW:0] TOP_ONE = (PW+1)'(1) << NPINS;
  localparam logic [PW-1:0] VALID = TOP_ONE[PW-1:0] - PW'(1);

  logic [PW-1:0] prev_q, status_q, enable_q;
  logic [PW-1:0] cur, sel, inv, eff_cur, eff_prev, hit;
  logic [PW-1:0] clr_mask, en_mask;

  assign cur = PW'(pin_level);
  assign sel = PW'(trig_level);
  assign inv = PW'(trig_invert);
  assign eff_cur  = cur ^ inv;
  assign eff_prev = prev_q ^ inv;
  assign hit = VALID & ((sel & ~eff_cur) | (~sel & eff_cur & ~eff_prev));

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign clr_mask[w*DW +: DW] = (bus_wr && bus_addr == AW'(STAT_BASE + 4*w)) ? bus_wdata : '0;
    assign en_mask[w*DW +: DW]  = (bus_wr && bus_addr == AW'(EN_BASE + 4*w)) ? '1 : '0;
  end

  logic [PW-1:0] en_data;
  always_comb begin
    for (int w = 0; w < NWORDS; w++) en_data[w*DW +: DW] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      enable_q <= '0;
    end else begin
      prev_q   <= cur & VALID;
      status_q <= ((status_q & ~clr_mask) | hit) & VALID;
      enable_q <= ((enable_q & ~en_mask) | (en_data & en_mask)) & VALID;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (bus_addr == AW'(STAT_BASE + 4*w)) bus_rdata = status_q[w*DW +: DW];
      if (bus_addr == AW'(EN_BASE + 4*w))   bus_rdata = enable_q[w*DW +: DW];
    end
  end

  assign irq = |(status_q & enable_q);

  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> ((~status_q & $past(status_q) & ~$past(clr_mask)) == '0));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (($past(hit) & ~status_q) == '0));

  a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (($past(sel & inv & cur & VALID) & ~status_q) == '0));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0 || status_q == '0) |-> !irq);

  a_r11_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(STAT_BASE + 4*(NWORDS-1)) || bus_addr == AW'(EN_BASE + 4*(NWORDS-1)))
      |-> ((PW'(bus_rdata) << ((NWORDS-1)*DW) & ~VALID) == '0));
endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/100ps
module gpio_irq_detect_bench;
  localparam int NP = 95;
  localparam int PW = 96;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pins = '0, tsel = '0, tinv = '0;
  logic [7:0] addr = '0;
  logic wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [PW-1:0] m_stat, m_en, m_prev;

  gpio_irq_detect u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_level(pins), .trig_level(tsel), .trig_invert(tinv),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #0.1; v = rdata;
  endtask

  task automatic model_edge();
    logic [PW-1:0] c, s, i, ec, ep, ev, clr, enm;
    c = PW'(pins); s = PW'(tsel); i = PW'(tinv);
    ec = c ^ i; ep = m_prev ^ i;
    ev = (s & ~ec) | (~s & ec & ~ep);
    clr = '0; enm = '0;
    for (int k = 0; k < 3; k++) begin
      if (wr && addr == 8'(8'h80 + 4*k)) clr[k*32 +: 32] = wdata;
      if (wr && addr == 8'(8'h90 + 4*k)) enm[k*32 +: 32] = '1;
    end
    m_stat = ((m_stat & ~clr) | ev) & {1'b0, {NP{1'b1}}};
    m_en = ((m_en & ~enm) | ({3{wdata}} & enm)) & {1'b0, {NP{1'b1}}};
    m_prev = c;
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 0; pins = '0; tsel = '0; tinv = '0; wr = 0;
    m_stat = '0; m_en = '0; m_prev = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  logic [31:0] v;
  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    for (int k = 0; k < 3; k++) begin
      rd(8'(8'h80 + 4*k), v); chk("R10 status reset", v, 0);
      rd(8'(8'h90 + 4*k), v); chk("R10 enable reset", v, 0);
    end
    chk("R10 irq reset", 32'(irq), 0);
    rd(8'hA0, v); chk("R9 unmapped read", v, 0);

    pins[0] = 1; tick();
    rd(8'h80, v); chk("R1 rising edge", v, 32'h1);
    tick();
    write(8'h80, 32'h1);
    rd(8'h80, v); chk("R1 held high no refire after clear", v, 0);

    tinv[1] = 1; tick();
    pins[1] = 1; tick();
    rd(8'h80, v); chk("R2 rising ignored in falling mode", v, 0);
    pins[1] = 0; tick();
    rd(8'h80, v); chk("R2 falling edge", v, 32'h2);
    write(8'h80, 32'h0);
    rd(8'h80, v); chk("R5 write zero keeps status", v, 32'h2);
    write(8'h80, 32'h2);
    rd(8'h80, v); chk("R5 write one clears", v, 0);

    tsel[40] = 1; tick();
    rd(8'h84, v); chk("R3 level low sets", v, 32'h100);
    write(8'h84, 32'h100);
    rd(8'h84, v); chk("R7 set wins over clear", v, 32'h100);
    pins[40] = 1; tick();
    write(8'h84, 32'h100);
    rd(8'h84, v); chk("R3 clear after level gone", v, 0);

    tsel[94] = 1; tinv[94] = 1; pins[94] = 1; tick();
    rd(8'h88, v); chk("R4 level high sets pin 94", v, 32'h4000_0000);
    chk("R6 status without enable no irq", 32'(irq), 0);
    write(8'h98, 32'hFFFF_FFFF);
    rd(8'h98, v); chk("R11 enable pad bit reads zero", v, 32'h7FFF_FFFF);
    chk("R8 irq with enabled status", 32'(irq), 1);
    write(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, v); chk("R4 level re-sets after clear", v, 32'h4000_0000);
    pins[94] = 0; tick();
    write(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, v); chk("R11 status top word cleared", v, 0);
    chk("R8 irq drops", 32'(irq), 0);
    write(8'h98, 32'h0);

    do_reset();
    pins = '1; tick();
    rd(8'h80, v); chk("R10 prev sample reset gives edge", v, 32'hFFFF_FFFF);

    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [PW-1:0] r;
      int a;
      r = {$urandom, $urandom, $urandom};
      pins = r[NP-1:0];
      if (n % 16 == 0) begin
        r = {$urandom, $urandom, $urandom}; tsel = r[NP-1:0];
        r = {$urandom, $urandom, $urandom}; tinv = r[NP-1:0];
      end
      if ($urandom % 4 == 0) begin
        a = $urandom % 7;
        addr = (a < 3) ? 8'(8'h80 + 4*a) : (a < 6) ? 8'(8'h90 + 4*(a-3)) : 8'hA0;
        wdata = $urandom; wr = 1;
      end
      tick();
      chk("R8 irq vs model", 32'(irq), 32'(|(m_stat & m_en)));
      a = $urandom % 3;
      rd(8'(8'h80 + 4*a), v); chk("R9 status word vs model", v, m_stat[a*32 +: 32]);
      rd(8'(8'h90 + 4*a), v); chk("R9 enable word vs model", v, m_en[a*32 +: 32]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule